// File: doc/BRIEF.md
# Bus Error Interrupt Status Register

This block keeps a small set of sticky error flags for a PCI bus interface and raises one interrupt request while any of them is set. Four of the flags record bus errors: a target abort, a master abort, and a parity error reported on a read or on a write data phase. Each of these is a one-cycle event pulse, and it is recorded only while some other device owns the bus. The fifth flag comes from a monitor inside the block. The monitor counts data-phase cycles in which the initiator-ready signal stays low and flags a master bus timeout once a stall reaches its limit.

The register can be reached from two sides. The local host reads the word and clears flags by writing ones. The PCI configuration side sees the same word but has no write path, so anything it writes is dropped. Protocol decoding, masking and address decode are done by neighbouring logic.

Top module: `pci_err_status`

## Requirements
- R1: After a synchronous reset every flag is 0, both read ports return 0x00000000 and `irq_o` is 0.
- R2: The read word puts the timeout flag at bit 11, target abort at bit 3, master abort at bit 2, read parity error at bit 1 and write parity error at bit 0. Bits 31:12 and 10:4 always read 0, and host writes to them change nothing.
- R3: The timeout flag sets at the clock edge that ends the 8th consecutive cycle with `data_phase_i`=1 and `irdy_i`=0. The count starts again whenever `irdy_i` is 1 or `data_phase_i` is 0, so 7 stalled cycles followed by a break set nothing.
- R4: A single stall sets the timeout flag only once. If the host clears the flag while the same stall goes on, the flag stays clear until a new stall reaches the limit.
- R5: A target abort, master abort or parity error pulse sets its flag only when `ext_master_i`=1. When `ext_master_i`=0 it is ignored.
- R6: `perr_i` with `xfer_write_i`=0 sets the read parity flag (bit 1). `perr_i` with `xfer_write_i`=1 sets the write parity flag (bit 0).
- R7: When `host_wr_i`=1, a 1 in a flag's bit of `host_wdata_i` clears that flag and a 0 leaves it alone. Apart from this, a set flag stays set.
- R8: If an event and a host clear reach the same flag in the same cycle, the flag ends up set.
- R9: `cfg_rdata_o` always equals `host_rdata_o`. `cfg_wr_i` and `cfg_wdata_i` have no effect on any flag.
- R10: `irq_o` is a register equal to the OR of all flags. It changes at the same clock edge as the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_master_i | input | 1 | Another device currently owns the bus |
| tgt_abort_i | input | 1 | One-cycle target-abort event |
| mst_abort_i | input | 1 | One-cycle master-abort event |
| perr_i | input | 1 | One-cycle parity-error event |
| xfer_write_i | input | 1 | Direction of the current data phase, 1 = write |
| data_phase_i | input | 1 | A data transfer is in progress |
| irdy_i | input | 1 | Initiator ready, active high |
| host_wr_i | input | 1 | Host write strobe (write-one-to-clear) |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Status word seen by the host |
| cfg_wr_i | input | 1 | Configuration-side write strobe (ignored) |
| cfg_wdata_i | input | 32 | Configuration-side write data (ignored) |
| cfg_rdata_o | output | 32 | Status word seen by the configuration side |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The case that needs the most care is an event pulse and a host write-one-to-clear landing on the same flag in the same cycle. The bench provokes it twice. A target-abort pulse is issued together with a host write that clears bit 3, and a stall is allowed to hit its limit on the cycle the host clears bit 11. In both cases the scoreboard expects the flag to be set after that edge, with `irq_o` high. A related case is a host clear that lands in the middle of a stall that is still going on. There the scoreboard expects the timeout flag to stay clear, because the stall already fired once.

// File: rtl/pci_errstat_pkg.sv
package pci_errstat_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_FLAGS = 5;

    // Bit positions in the status word; decoded by software, so fixed.
    localparam int POS_TMO   = 11;
    localparam int POS_TABT  = 3;
    localparam int POS_MABT  = 2;
    localparam int POS_RPERR = 1;
    localparam int POS_WPERR = 0;

    typedef struct packed {
        logic tmo;
        logic tabt;
        logic mabt;
        logic rperr;
        logic wperr;
    } flag_set_t;

    function automatic logic [WORD_W-1:0] flags_to_word(input flag_set_t f);
        logic [WORD_W-1:0] w;
        w            = '0;
        w[POS_TMO]   = f.tmo;
        w[POS_TABT]  = f.tabt;
        w[POS_MABT]  = f.mabt;
        w[POS_RPERR] = f.rperr;
        w[POS_WPERR] = f.wperr;
        return w;
    endfunction

    function automatic flag_set_t word_to_flags(input logic [WORD_W-1:0] w);
        flag_set_t f;
        f.tmo   = w[POS_TMO];
        f.tabt  = w[POS_TABT];
        f.mabt  = w[POS_MABT];
        f.rperr = w[POS_RPERR];
        f.wperr = w[POS_WPERR];
        return f;
    endfunction

endpackage

// File: rtl/pci_errstat_stall_mon.sv
module pci_errstat_stall_mon #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic data_phase_i,
    input  logic irdy_i,
    output logic fire_o
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST_STALL = CNT_W'(LIMIT - 1);
    localparam logic [CNT_W-1:0] SATURATED  = CNT_W'(LIMIT);

    logic             stall;
    logic [CNT_W-1:0] cnt_q;

    assign stall  = data_phase_i && !irdy_i;
    assign fire_o = stall && (cnt_q == LAST_STALL);

    // Count stalled cycles; saturate past the limit so one stall fires once.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!stall) begin
            cnt_q <= '0;
        end else if (cnt_q != SATURATED) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r4_single_fire: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> !fire_o);

    a_r3_break_restarts: assert property (@(posedge clk) disable iff (rst)
        (!stall && (LIMIT > 1)) |=> !fire_o);

endmodule

// File: rtl/pci_errstat_evt_qual.sv
module pci_errstat_evt_qual
    import pci_errstat_pkg::*;
(
    input  logic      ext_master_i,
    input  logic      tgt_abort_i,
    input  logic      mst_abort_i,
    input  logic      perr_i,
    input  logic      xfer_write_i,
    input  logic      tmo_fire_i,
    output flag_set_t set_o
);
    always_comb begin
        set_o       = '0;
        set_o.tmo   = tmo_fire_i;
        set_o.tabt  = ext_master_i && tgt_abort_i;
        set_o.mabt  = ext_master_i && mst_abort_i;
        set_o.rperr = ext_master_i && perr_i && !xfer_write_i;
        set_o.wperr = ext_master_i && perr_i &&  xfer_write_i;
    end

    always_comb begin
        a_r6_perr_one_side: assert ($countones({set_o.rperr, set_o.wperr}) <= 1);
    end

endmodule

// File: rtl/pci_errstat_flag_bank.sv
module pci_errstat_flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o,
    output logic         irq_o
);
    logic [N-1:0] flag_q;
    logic [N-1:0] flag_d;
    logic         irq_q;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_bit
            // Set dominates clear so that an event is never lost.
            assign flag_d[i] = set_i[i] | (flag_q[i] & ~clr_i[i]);

            always_ff @(posedge clk) begin
                if (rst) flag_q[i] <= 1'b0;
                else     flag_q[i] <= flag_d[i];
            end

            a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
                set_i[i] |=> flag_q[i]);

            a_r7_w1c: assert property (@(posedge clk) disable iff (rst)
                (clr_i[i] && !set_i[i]) |=> !flag_q[i]);

            a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
                (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |flag_d;
    end

    assign flag_o = flag_q;
    assign irq_o  = irq_q;

    a_r10_irq_tracks: assert property (@(posedge clk) disable iff (rst)
        irq_q == (flag_q != '0));

endmodule

// File: rtl/pci_err_status.sv
module pci_err_status
    import pci_errstat_pkg::*;
#(
    parameter int STALL_LIMIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_master_i,
    input  logic              tgt_abort_i,
    input  logic              mst_abort_i,
    input  logic              perr_i,
    input  logic              xfer_write_i,
    input  logic              data_phase_i,
    input  logic              irdy_i,
    input  logic              host_wr_i,
    input  logic [WORD_W-1:0] host_wdata_i,
    output logic [WORD_W-1:0] host_rdata_o,
    input  logic              cfg_wr_i,
    input  logic [WORD_W-1:0] cfg_wdata_i,
    output logic [WORD_W-1:0] cfg_rdata_o,
    output logic              irq_o
);
    logic        tmo_fire;
    flag_set_t   set_vec;
    flag_set_t   clr_vec;
    flag_set_t   flags_q;
    logic [WORD_W-1:0] status_word;

    pci_errstat_stall_mon #(.LIMIT(STALL_LIMIT)) u_stall (
        .clk          (clk),
        .rst          (rst),
        .data_phase_i (data_phase_i),
        .irdy_i       (irdy_i),
        .fire_o       (tmo_fire)
    );

    pci_errstat_evt_qual u_qual (
        .ext_master_i (ext_master_i),
        .tgt_abort_i  (tgt_abort_i),
        .mst_abort_i  (mst_abort_i),
        .perr_i       (perr_i),
        .xfer_write_i (xfer_write_i),
        .tmo_fire_i   (tmo_fire),
        .set_o        (set_vec)
    );

    // Only the host side may clear; the configuration side has no write path.
    assign clr_vec = host_wr_i ? word_to_flags(host_wdata_i) : '0;

    pci_errstat_flag_bank #(.N(NUM_FLAGS)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .flag_o (flags_q),
        .irq_o  (irq_o)
    );

    assign status_word  = flags_to_word(flags_q);
    assign host_rdata_o = status_word;
    assign cfg_rdata_o  = status_word;

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (host_rdata_o[31:12] == '0) && (host_rdata_o[10:4] == '0));

    a_r5_internal_master: assert property (@(posedge clk) disable iff (rst)
        !ext_master_i |=> !($rose(flags_q.tabt) || $rose(flags_q.mabt) ||
                            $rose(flags_q.rperr) || $rose(flags_q.wperr)));

    a_r9_cfg_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_i && (cfg_wdata_i != '0) && !host_wr_i && (set_vec == '0))
            |=> $stable(flags_q));

endmodule

// File: tb/tb_pci_err_status.sv
`timescale 1ns/1ps
module tb_pci_err_status;

    localparam int LIM = 8;
    localparam logic [31:0] IMPL_MASK = 32'h0000_080F;

    typedef struct {
        logic [31:0] word;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        ext_master_i, tgt_abort_i, mst_abort_i, perr_i, xfer_write_i;
    logic        data_phase_i, irdy_i, host_wr_i, cfg_wr_i;
    logic [31:0] host_wdata_i, cfg_wdata_i, host_rdata_o, cfg_rdata_o;
    logic        irq_o;

    int total = 0;
    int bad   = 0;
    bit finished = 0;
    exp_t q[$];
    logic [31:0] m_flags;
    int          m_cnt;

    always #2 clk = ~clk;

    pci_err_status #(.STALL_LIMIT(LIM)) dut (
        .clk(clk), .rst(rst), .ext_master_i(ext_master_i),
        .tgt_abort_i(tgt_abort_i), .mst_abort_i(mst_abort_i), .perr_i(perr_i),
        .xfer_write_i(xfer_write_i), .data_phase_i(data_phase_i), .irdy_i(irdy_i),
        .host_wr_i(host_wr_i), .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o),
        .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
        .irq_o(irq_o)
    );

    // Driver: applies one cycle of stimulus, updates the bench model, queues the result.
    task automatic cyc(input logic ext, input logic ta, input logic ma, input logic pe,
                       input logic wr, input logic dp, input logic ir,
                       input logic hw, input logic [31:0] hd,
                       input logic cw, input logic [31:0] cd, input string tag);
        logic [31:0] setv;
        logic [31:0] clrv;
        ext_master_i = ext; tgt_abort_i = ta; mst_abort_i = ma; perr_i = pe;
        xfer_write_i = wr; data_phase_i = dp; irdy_i = ir;
        host_wr_i = hw; host_wdata_i = hd; cfg_wr_i = cw; cfg_wdata_i = cd;
        setv = '0;
        if (dp && !ir) begin
            if (m_cnt == LIM - 1) setv[11] = 1'b1;
            if (m_cnt < LIM) m_cnt++;
        end else begin
            m_cnt = 0;
        end
        if (ext) begin
            if (ta)        setv[3] = 1'b1;
            if (ma)        setv[2] = 1'b1;
            if (pe && !wr) setv[1] = 1'b1;
            if (pe && wr)  setv[0] = 1'b1;
        end
        clrv    = hw ? (hd & IMPL_MASK) : '0;
        m_flags = (m_flags & ~clrv) | setv;
        @(posedge clk);
        #1;
        q.push_back('{m_flags, tag});
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 0, 0, 0, 1, 0, '0, 0, '0, tag);
    endtask

    task automatic stall(input int n, input string tag);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 1, 0, 0, '0, 0, '0, tag);
    endtask

    task automatic hclr(input logic [31:0] d, input string tag);
        cyc(0, 0, 0, 0, 0, 0, 1, 1, d, 0, '0, tag);
    endtask

    // Monitor: pops the expected word and compares both ports and the interrupt.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (host_rdata_o !== e.word || cfg_rdata_o !== e.word || irq_o !== (e.word != 0)) begin
                bad++;
                $display("FAIL %s: host=%h cfg=%h irq=%b expected word=%h irq=%b",
                         e.tag, host_rdata_o, cfg_rdata_o, irq_o, e.word, (e.word != 0));
            end
        end
    end

    initial begin
        rst = 1'b1;
        ext_master_i = 0; tgt_abort_i = 0; mst_abort_i = 0; perr_i = 0; xfer_write_i = 0;
        data_phase_i = 0; irdy_i = 1; host_wr_i = 0; host_wdata_i = '0;
        cfg_wr_i = 0; cfg_wdata_i = '0;
        m_flags = '0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle("R1 reset state");

        // Aborts from an external master, then write-one-to-clear behaviour.
        cyc(1, 1, 0, 0, 0, 0, 1, 0, '0, 0, '0, "R2 R5 target abort bit 3");
        cyc(1, 0, 1, 0, 0, 0, 1, 0, '0, 0, '0, "R2 R5 master abort bit 2");
        idle("R7 flags sticky");
        hclr(32'h0000_0008, "R7 clear bit 3 only");
        hclr(32'h0000_0000, "R7 write zero keeps flags");
        hclr(32'hFFFF_FFFF, "R7 R10 clear all");

        // Internal master: all error events ignored.
        cyc(0, 1, 1, 1, 0, 0, 1, 0, '0, 0, '0, "R5 internal master read");
        cyc(0, 0, 0, 1, 1, 0, 1, 0, '0, 0, '0, "R5 internal master write");

        // Parity direction.
        cyc(1, 0, 0, 1, 0, 0, 1, 0, '0, 0, '0, "R6 read parity bit 1");
        cyc(1, 0, 0, 1, 1, 0, 1, 0, '0, 0, '0, "R6 write parity bit 0");
        hclr(32'hFFFF_FFFF, "R7 clear all");

        // Timeout boundaries.
        stall(7, "R3 seven stalled cycles");
        cyc(0, 0, 0, 0, 0, 1, 1, 0, '0, 0, '0, "R3 irdy restarts count");
        stall(7, "R3 seven again");
        idle("R3 phase end restarts count");
        stall(8, "R3 eighth stall sets bit 11");
        cyc(0, 0, 0, 0, 0, 1, 0, 1, 32'h0000_0800, 0, '0, "R4 clear during stall");
        stall(6, "R4 no refire in same stall");
        cyc(0, 0, 0, 0, 0, 1, 1, 0, '0, 0, '0, "R4 stall ends");
        stall(7, "R4 new stall below limit");
        cyc(0, 0, 0, 0, 0, 1, 0, 1, 32'h0000_0800, 0, '0, "R8 timeout fires with clear");
        hclr(32'h0000_0800, "R7 clear timeout");

        // Set wins over clear on the same flag.
        cyc(1, 1, 0, 0, 0, 0, 1, 1, 32'h0000_0008, 0, '0, "R8 R10 abort with clear");

        // Configuration-side write and reserved bits.
        cyc(0, 0, 0, 0, 0, 0, 1, 0, '0, 1, 32'hFFFF_FFFF, "R9 cfg write ignored");
        hclr(32'hFFFF_F7F0, "R2 reserved write ignored");
        hclr(32'h0000_0008, "R1 R10 back to zero");
        idle("R10 irq low");

        repeat (2) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule